// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a request, given as a run of memory segments, into the descriptor table that a bus-master disk DMA controller walks. Each segment arrives as a start address and a byte length on a valid/ready stream, and the last segment of a request is marked. Each output entry is one 64-bit descriptor: a 32-bit base address and a 32-bit control word. The block cuts each segment so that no descriptor crosses a 64 KiB address window. In standard layout it also replaces any piece of exactly 64 KiB with two 32 KiB descriptors, because some controllers read a zero count field as zero bytes and not as 64 KiB.

When the final segment has been cut, the block marks the last descriptor of the table and then gives one result: either the number of descriptors, or an error code. Three errors exist: too many descriptors, an empty table, and a misaligned length. After an error, the rest of the request is read and dropped up to its last segment. The descriptors already delivered for that request must be thrown away by the consumer.

Both streams follow valid/ready rules. A producer holds a beat stable while valid is high and ready is low, and a transfer takes place on a clock edge where both are high. The block stops taking segments while it is still cutting the current one. Its descriptor output holds still under back-pressure. The layout select `alt_mode` must stay constant from the first segment of a request until that request's result. `LEN_W` must be at least 17.

Top module: `prd_sg_builder`

## Requirements
- R1: In standard layout, each piece is min(0x10000 − addr[15:0], remaining length), with 0x10000 turned into 0x8000 (see R3). Pieces are delivered in address order, are contiguous, and together cover every segment of the request in the order the segments arrived. No descriptor spans a 64 KiB boundary.
- R2: In standard layout, the control word carries the byte count in bits 15:0, zeros in bits 30:16, and the end flag in bit 31. The address is delivered on `ent_addr`.
- R3: In standard layout, a piece of exactly 0x10000 bytes is sent as two descriptors of 0x8000 bytes, at A and A+0x8000. Each of the two counts toward the table limit.
- R4: In standard layout, bit 31 of the control word is 1 on the last descriptor of a successful table and 0 on every other descriptor.
- R5: In alternate layout (`alt_mode`=1), bits 31:16 hold bytes/4 − 1 and bits 15:0 are zero. No 32 KiB split is made, so a 64 KiB piece gives 0x3FFF, and no end flag is written. Lengths must be multiples of 4.
- R6: After a successful request, `res_valid` pulses for one cycle, once the final descriptor has been accepted. It comes with `res_err`=0 and `res_count` equal to the number of descriptors, which is between 1 and MAX_ENTRIES.
- R7: A request that needs more than MAX_ENTRIES descriptors ends with `res_err`=1 and `res_count`=0. Fewer than MAX_ENTRIES of its descriptors are delivered, none of them flagged as last, and its remaining segments are consumed.
- R8: A request whose segments are all zero-length gives no descriptor and ends with `res_err`=2 and `res_count`=0.
- R9: An odd segment length (standard layout), or a length that is not a multiple of 4 (alternate layout), ends the request with `res_err`=3 and `res_count`=0. The remaining segments are consumed. The next request is handled normally.
- R10: While `ent_valid` is high and `ent_ready` is low, the descriptor stays unchanged. No descriptor is lost or repeated under any back-pressure pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_mode | input | 1 | 0: standard layout, 1: alternate layout |
| seg_valid | input | 1 | Segment beat valid |
| seg_ready | output | 1 | Block can take a segment |
| seg_addr | input | ADDR_W | Segment start address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the request |
| ent_valid | output | 1 | Descriptor valid |
| ent_ready | input | 1 | Consumer takes the descriptor |
| ent_addr | output | ADDR_W | Descriptor base address |
| ent_word | output | 32 | Descriptor control word |
| res_valid | output | 1 | One-cycle result strobe |
| res_err | output | 2 | 0 ok, 1 overflow, 2 empty, 3 alignment |
| res_count | output | CNT_W | Descriptor count on success, else 0 |

## Verification
The cursor is the running address and the remaining length of the current segment. A wrong cursor shows up on the very next descriptor as a shifted address or a wrong count. The held-back descriptor can be lost or repeated, or the table counter can drift. Either fault shows up at the end of the request: the end flag lands on the wrong descriptor, `res_count` comes out wrong, or an overflow is reported one descriptor early or late at the exact-limit boundary. A state machine stuck after an error shows up as `seg_ready` never rising again, or as a missing result strobe on the following request.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_OVERFLOW = 2'd1,
    ERR_EMPTY    = 2'd2,
    ERR_ALIGN    = 2'd3
  } prd_err_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_FLUSH,
    ST_SKIP,
    ST_DONE
  } prd_state_e;

  localparam logic [16:0] WINDOW_BYTES = 17'h10000;
  localparam logic [16:0] HALF_BYTES   = 17'h08000;
endpackage

// File: rtl/prd_chunker.sv
module prd_chunker #(
  parameter int LEN_W = 20
) (
  input  logic [15:0]      addr_lo,
  input  logic [LEN_W-1:0] rem,
  input  logic             alt_mode,
  output logic [16:0]      bytes,
  output logic             seg_end
);
  import prd_pkg::*;

  localparam int CW = (LEN_W > 17) ? LEN_W : 17;

  logic [16:0]   room;
  logic [CW-1:0] rem_w;
  logic [CW-1:0] room_w;
  logic [16:0]   take;

  always_comb begin
    room   = WINDOW_BYTES - {1'b0, addr_lo};
    rem_w  = CW'(rem);
    room_w = CW'(room);
    take   = (rem_w < room_w) ? rem_w[16:0] : room;
    if (!alt_mode && take == WINDOW_BYTES)
      bytes = HALF_BYTES;
    else
      bytes = take;
    seg_end = (CW'(bytes) == rem_w);
  end
endmodule

// File: rtl/prd_entry_fmt.sv
module prd_entry_fmt (
  input  logic [16:0] bytes,
  input  logic        eot,
  input  logic        alt_mode,
  output logic [31:0] word
);
  logic [14:0] quads_m1;

  always_comb begin
    quads_m1 = bytes[16:2] - 15'd1;
    if (alt_mode)
      word = {1'b0, quads_m1, 16'h0000};
    else
      word = {eot, 15'h0000, bytes[15:0]};
  end
endmodule

// File: rtl/prd_sg_builder.sv
module prd_sg_builder #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 20,
  parameter int MAX_ENTRIES = 256,
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_mode,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [ADDR_W-1:0] seg_addr,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_last,
  output logic              ent_valid,
  input  logic              ent_ready,
  output logic [ADDR_W-1:0] ent_addr,
  output logic [31:0]       ent_word,
  output logic              res_valid,
  output logic [1:0]        res_err,
  output logic [CNT_W-1:0]  res_count
);
  import prd_pkg::*;

  prd_state_e        state;
  prd_err_e          err;
  logic              act;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_rem;
  logic              cur_last;
  logic              hold_v;
  logic [ADDR_W-1:0] hold_addr;
  logic [16:0]       hold_bytes;
  logic              out_v;
  logic [ADDR_W-1:0] out_addr;
  logic [31:0]       out_word;
  logic [CNT_W-1:0]  count;
  logic              res_v;
  prd_err_e          res_e;
  logic [CNT_W-1:0]  res_c;

  logic [16:0] chunk_bytes;
  logic        chunk_end;
  logic [31:0] fmt_word;
  logic        out_free, seg_acc, len_bad, step, over, push_out;

  prd_chunker #(.LEN_W(LEN_W)) u_chunk (
    .addr_lo (cur_addr[15:0]),
    .rem     (cur_rem),
    .alt_mode(alt_mode),
    .bytes   (chunk_bytes),
    .seg_end (chunk_end)
  );

  prd_entry_fmt u_fmt (
    .bytes   (hold_bytes),
    .eot     (state == ST_FLUSH),
    .alt_mode(alt_mode),
    .word    (fmt_word)
  );

  always_comb begin
    out_free  = !out_v || ent_ready;
    seg_ready = (state == ST_RUN && !act) || (state == ST_SKIP);
    seg_acc   = seg_valid && seg_ready;
    len_bad   = alt_mode ? (seg_len[1:0] != 2'b00) : seg_len[0];
    step      = (state == ST_RUN) && act && (!hold_v || out_free);
    over      = step && (count == CNT_W'(MAX_ENTRIES));
    push_out  = (step && !over && hold_v) ||
                (state == ST_FLUSH && hold_v && out_free);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      err        <= ERR_NONE;
      act        <= 1'b0;
      cur_addr   <= '0;
      cur_rem    <= '0;
      cur_last   <= 1'b0;
      hold_v     <= 1'b0;
      hold_addr  <= '0;
      hold_bytes <= '0;
      out_v      <= 1'b0;
      out_addr   <= '0;
      out_word   <= '0;
      count      <= '0;
      res_v      <= 1'b0;
      res_e      <= ERR_NONE;
      res_c      <= '0;
    end else begin
      res_v <= 1'b0;
      if (push_out) begin
        out_v    <= 1'b1;
        out_addr <= hold_addr;
        out_word <= fmt_word;
      end else if (ent_ready) begin
        out_v <= 1'b0;
      end

      case (state)
        ST_RUN: begin
          if (seg_acc) begin
            if (len_bad) begin
              hold_v <= 1'b0;
              err    <= ERR_ALIGN;
              state  <= seg_last ? ST_DONE : ST_SKIP;
            end else begin
              act      <= (seg_len != '0);
              cur_addr <= seg_addr;
              cur_rem  <= seg_len;
              cur_last <= seg_last;
              if (seg_len == '0 && seg_last)
                state <= ST_FLUSH;
            end
          end else if (step) begin
            if (over) begin
              hold_v <= 1'b0;
              act    <= 1'b0;
              err    <= ERR_OVERFLOW;
              state  <= cur_last ? ST_DONE : ST_SKIP;
            end else begin
              hold_v     <= 1'b1;
              hold_addr  <= cur_addr;
              hold_bytes <= chunk_bytes;
              count      <= count + 1'b1;
              cur_addr   <= cur_addr + ADDR_W'(chunk_bytes);
              cur_rem    <= cur_rem - LEN_W'(chunk_bytes);
              if (chunk_end) begin
                act <= 1'b0;
                if (cur_last)
                  state <= ST_FLUSH;
              end
            end
          end
        end
        ST_FLUSH: begin
          if (!hold_v) begin
            err   <= ERR_EMPTY;
            state <= ST_DONE;
          end else if (out_free) begin
            hold_v <= 1'b0;
            state  <= ST_DONE;
          end
        end
        ST_SKIP: begin
          if (seg_acc && seg_last)
            state <= ST_DONE;
        end
        ST_DONE: begin
          if (!out_v) begin
            res_v <= 1'b1;
            res_e <= err;
            res_c <= (err == ERR_NONE) ? count : '0;
            count <= '0;
            err   <= ERR_NONE;
            state <= ST_RUN;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign ent_valid = out_v;
  assign ent_addr  = out_addr;
  assign ent_word  = out_word;
  assign res_valid = res_v;
  assign res_err   = res_e;
  assign res_count = res_c;
endmodule

// File: rtl/prd_sg_builder_chk.sv
module prd_sg_builder_chk #(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 256,
  parameter int CNT_W       = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alt_mode,
  input logic              ent_valid,
  input logic              ent_ready,
  input logic [ADDR_W-1:0] ent_addr,
  input logic [31:0]       ent_word,
  input logic              res_valid,
  input logic [1:0]        res_err,
  input logic [CNT_W-1:0]  res_count
);
  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !alt_mode |-> ({1'b0, ent_addr[15:0]} + {1'b0, ent_word[15:0]}) <= 17'h10000); // R1

  AST_STD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !alt_mode |-> ent_word[15:0] != 16'h0 && ent_word[30:16] == 15'h0); // R2

  AST_ALT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && alt_mode |-> ent_word[15:0] == 16'h0); // R5

  AST_ENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_addr) && $stable(ent_word)); // R10

  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err != 2'd0 |-> res_count == '0); // R7

  AST_OK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err == 2'd0 |-> res_count != '0 && res_count <= CNT_W'(MAX_ENTRIES)); // R6

  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R6
endmodule

bind prd_sg_builder prd_sg_builder_chk #(
  .ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode),
  .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_addr(ent_addr), .ent_word(ent_word),
  .res_valid(res_valid), .res_err(res_err), .res_count(res_count)
);

// File: tb/prd_sg_builder_test.sv
`timescale 1ns/1ps
module prd_sg_builder_test;
  localparam int MAXE  = 8;
  localparam int LEN_W = 20;
  localparam int CNT_W = $clog2(MAXE + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alt_mode = 1'b0;
  logic seg_valid = 1'b0;
  logic seg_ready;
  logic [31:0] seg_addr = '0;
  logic [LEN_W-1:0] seg_len = '0;
  logic seg_last = 1'b0;
  logic ent_valid;
  logic ent_ready = 1'b1;
  logic [31:0] ent_addr;
  logic [31:0] ent_word;
  logic res_valid;
  logic [1:0] res_err;
  logic [CNT_W-1:0] res_count;

  always #2.5 clk = ~clk;

  prd_sg_builder #(.ADDR_W(32), .LEN_W(LEN_W), .MAX_ENTRIES(MAXE)) uut (
    .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_addr(ent_addr), .ent_word(ent_word),
    .res_valid(res_valid), .res_err(res_err), .res_count(res_count)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] sa [8];
  logic [LEN_W-1:0] sl [8];
  int ns;
  logic [63:0] exp_e [$];
  logic [63:0] got_e [$];
  int exp_err;
  bit res_seen;
  int got_err, got_cnt;
  bit bp_on = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bp_on) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ent_ready = lfsr[0] | lfsr[2];
    end else begin
      ent_ready = 1'b1;
    end
    if (rst_n) begin
      if (ent_valid && ent_ready) got_e.push_back({ent_addr, ent_word});
      if (res_valid) begin
        res_seen = 1'b1;
        got_err  = int'(res_err);
        got_cnt  = int'(res_count);
      end
    end
  end

  task automatic build_exp();
    logic [31:0] a, r, room, bc, w;
    bit bad;
    exp_e.delete();
    exp_err = 0;
    for (int i = 0; i < ns; i++) begin
      if (exp_err == 0) begin
        bad = alt_mode ? (sl[i][1:0] != 2'b00) : sl[i][0];
        if (bad) exp_err = 3;
        else begin
          a = sa[i];
          r = 32'(sl[i]);
          while (r != 0 && exp_err == 0) begin
            room = 32'h10000 - {16'h0, a[15:0]};
            bc = (r < room) ? r : room;
            if (!alt_mode && bc == 32'h10000) bc = 32'h8000;
            if (exp_e.size() == MAXE) exp_err = 1;
            else begin
              w = alt_mode ? (((bc / 4) - 1) << 16) : bc;
              exp_e.push_back({a, w});
              a = a + bc;
              r = r - bc;
            end
          end
        end
      end
    end
    if (exp_err == 0 && exp_e.size() == 0) exp_err = 2;
    if (exp_err == 0 && !alt_mode) exp_e[exp_e.size()-1][31] = 1'b1;
  endtask

  task automatic run_req(input string ph);
    string et, t;
    build_exp();
    got_e.delete();
    res_seen = 1'b0;
    for (int i = 0; i < ns; i++) begin
      @(negedge clk);
      seg_valid = 1'b1;
      seg_addr  = sa[i];
      seg_len   = sl[i];
      seg_last  = (i == ns - 1);
      while (!seg_ready) @(negedge clk);
    end
    @(negedge clk);
    seg_valid = 1'b0;
    while (!res_seen) @(negedge clk);
    case (exp_err)
      0: et = "R6";
      1: et = "R7";
      2: et = "R8";
      default: et = "R9";
    endcase
    chk(got_err == exp_err, {ph, et, " result code"}, 64'(got_err), 64'(exp_err));
    if (exp_err == 0) begin
      chk(got_cnt == exp_e.size(), {ph, "R6 count"}, 64'(got_cnt), 64'(exp_e.size()));
      chk(got_e.size() == exp_e.size(), {ph, "R1 entries delivered"}, 64'(got_e.size()), 64'(exp_e.size()));
      for (int k = 0; k < exp_e.size() && k < got_e.size(); k++) begin
        if (alt_mode) t = "R5";
        else if (k == exp_e.size() - 1) t = "R4";
        else if (exp_e[k][15:0] == 16'h8000) t = "R3";
        else t = "R1/R2";
        chk(got_e[k] == exp_e[k], {ph, t, " entry"}, got_e[k], exp_e[k]);
      end
    end else begin
      chk(got_cnt == 0, {ph, et, " count zero"}, 64'(got_cnt), 64'd0);
      chk(got_e.size() < MAXE, {ph, et, " delivered below limit"}, 64'(got_e.size()), 64'(MAXE));
      for (int k = 0; k < got_e.size(); k++)
        if (!alt_mode)
          chk(got_e[k][31] == 1'b0, {ph, et, " no end flag"}, got_e[k], 64'd0);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic one_seg(input logic [31:0] a, input logic [LEN_W-1:0] l, input string ph);
    ns = 1; sa[0] = a; sl[0] = l;
    run_req(ph);
  endtask

  task automatic sweeps(input string ph);
    logic [15:0] los [6];
    logic [LEN_W-1:0] lens [7];
    logic [15:0] alos [4];
    logic [LEN_W-1:0] alens [5];
    los   = '{16'h0000, 16'h0002, 16'h7FFE, 16'h8000, 16'hFFF0, 16'hFFFE};
    lens  = '{20'h00002, 20'h07FFE, 20'h08000, 20'h0FFFE, 20'h10000, 20'h10002, 20'h2FFFE};
    alos  = '{16'h0000, 16'h0004, 16'h8000, 16'hFFFC};
    alens = '{20'h00004, 20'h08000, 20'h10000, 20'h10004, 20'h2FFFC};
    alt_mode = 1'b0;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 7; j++)
        one_seg({16'h1230 + 16'(i), los[i]}, lens[j], ph);
    alt_mode = 1'b1;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 5; j++)
        one_seg({16'h4560 + 16'(j), alos[i]}, alens[j], ph);
    alt_mode = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R6 actual=hung expected=result");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ent_valid == 1'b0, "R10 reset no entry", 64'(ent_valid), 64'd0);
    chk(res_valid == 1'b0, "R6 reset no result", 64'(res_valid), 64'd0);
    chk(seg_ready == 1'b1, "R10 reset ready", 64'(seg_ready), 64'd1);

    sweeps("");

    // multi-segment, with a zero-length segment in the middle
    ns = 3; sa[0] = 32'h0001_FFF8; sl[0] = 20'h00010;
    sa[1] = 32'h0009_0000; sl[1] = 20'h0; sa[2] = 32'h0003_4000; sl[2] = 20'h14000;
    run_req("");
    // exactly MAX_ENTRIES entries: succeeds
    one_seg(32'h0010_0000, 20'h40000, "");
    // one past the limit, within one segment
    one_seg(32'h0010_0000, 20'h40002, "");
    // overflow in the middle of a request, trailing segments skipped
    ns = 3; sa[0] = 32'h0020_0000; sl[0] = 20'h40000;
    sa[1] = 32'h0030_0000; sl[1] = 20'h00100; sa[2] = 32'h0040_0000; sl[2] = 20'h00100;
    run_req("");
    one_seg(32'h0000_1000, 20'h00200, "");
    // empty request
    ns = 2; sa[0] = 32'h0; sl[0] = 20'h0; sa[1] = 32'h100; sl[1] = 20'h0;
    run_req("");
    // odd length mid-request, then recovery
    ns = 3; sa[0] = 32'h5000; sl[0] = 20'h00100; sa[1] = 32'h6000; sl[1] = 20'h00003;
    sa[2] = 32'h7000; sl[2] = 20'h00100;
    run_req("");
    one_seg(32'h0000_8000, 20'h10000, "");
    // alternate layout: length not a multiple of 4
    alt_mode = 1'b1;
    one_seg(32'h0000_2000, 20'h00006, "");
    one_seg(32'h0000_0000, 20'h10000, "");
    alt_mode = 1'b0;

    // back-pressure phase
    bp_on = 1'b1;
    sweeps("R10 ");
    ns = 3; sa[0] = 32'h0001_FFF8; sl[0] = 20'h00010;
    sa[1] = 32'h0009_0000; sl[1] = 20'h0; sa[2] = 32'h0003_4000; sl[2] = 20'h14000;
    run_req("R10 ");
    one_seg(32'h0010_0000, 20'h40002, "R10 ");
    bp_on = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule